// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This block keeps the status, interrupt-cause and sequence-step registers of a small SCSI host controller and drives its interrupt request line. The command decoder, the bus phase logic and the data path are not part of the block. They reach it only as single-cycle event pulses: function complete, bus service, disconnect, and command complete together with a status byte. Software reaches the block through a byte-wide register port with a 4-bit address.

The block also holds a 24-bit transfer count, kept as three bytes. Each byte has a write shadow and a readable copy. It also holds a configuration byte, the last command byte and the status byte of the last reported completion. Reading the interrupt-cause register clears it. That read also releases a command completion that was held back because an interrupt was already pending.

Read data is registered. It appears on `reg_rdata` in the cycle after the clock edge that samples `reg_rd`. All side effects of a write or of a read take effect at that same edge.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset, `irq` is 0 and the registers read as follows: status (4) 0, interrupt cause (5) 0, sequence (6) 0, command (3) 0, completion status (9) 0, count bytes 0 and 1 give 0, address 2 gives the chip identifier (default 0xA2), and configuration (8) gives 0x07.
- R2: An event pulse ORs its cause bit into the interrupt-cause register (function complete bit 3, bus service bit 4, disconnect bit 5). It sets the pending bit (status bit 7), which is the `irq` output. While the pending bit is set, a further event keeps `irq` high.
- R3: A read of address 5 returns the cause value from before the read. The same read clears the cause register, the terminal-count bit (status bit 4) and the pending bit, and sets the sequence step (address 6) to 4. `irq` is low in the next cycle unless a held completion is released.
- R4: A completion that arrives while the pending bit is set changes no register. It is held with its status byte, and the next read of address 5 reports it. A completion that arrives in the same cycle as a read of address 5, with nothing held, is reported at once.
- R5: Reporting a completion sets status to 0x93 (pending, terminal count, phase 3), the cause register to 0x10, the sequence step to 0 and all readable count bytes to 0. It stores the status byte at address 9 and raises `irq`.
- R6: A write to a count byte (addresses 0 to 2) updates only its shadow. It clears status bit 4 and leaves the readable counts and the other status bits unchanged.
- R7: Address 2 returns the chip identifier until address 2 has been written once. After that it returns the readable high count byte, even when that byte is 0.
- R8: A write to address 3 stores the command byte, which is readable there. When bit 7 of that byte is set, the readable count bytes load the last values written to the shadows.
- R9: Command code 0x03 (bits 6:0) sets the cause register to 0x80. It raises `irq` only when bit 6 of the configuration byte is 0.
- R10: Command code 0x01 sets the cause register to 0x08 and the sequence step to 0, and leaves the pending bit unchanged.
- R11: Command code 0x02 returns every register, the held completion and the identifier visibility to the reset state of R1, and drops `irq`.
- R12: A write to any address other than 0, 1, 2, 3 and 8 changes no state. Reads of addresses other than 0 to 6, 8 and 9 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| ev_func_done | input | 1 | Function-complete event pulse |
| ev_bus_service | input | 1 | Bus-service event pulse |
| ev_disconnect | input | 1 | Disconnect event pulse |
| ev_cmd_done | input | 1 | Command-complete event pulse |
| cmd_done_status | input | 8 | Status byte sampled with `ev_cmd_done` |
| irq | output | 1 | Interrupt request, equal to the pending bit |

## Verification
A wrong pending bit shows on `irq` in the cycle after the event or read that should have changed it, so the line is compared after every operation. A completion that is lost or reported twice while held shows up at the next cause read. It appears at address 9 and as status 0x93, and `irq` fails to return high at the same edge. Wrong count shadows or a wrong written-once flag stay hidden until a DMA-flagged command or a read of address 2, so the random mix reloads and reads those bytes often.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
   // register addresses
   localparam int unsigned ADR_CMD  = 3;
   localparam int unsigned ADR_STAT = 4;
   localparam int unsigned ADR_INTR = 5;
   localparam int unsigned ADR_SEQ  = 6;
   localparam int unsigned ADR_CFG  = 8;
   localparam int unsigned ADR_CST  = 9;

   // status bits
   localparam int unsigned ST_INT = 7;
   localparam int unsigned ST_TC  = 4;
   localparam logic [2:0]  PH_STATUS = 3'd3;

   // interrupt cause bits
   localparam int unsigned IC_RST = 7;
   localparam int unsigned IC_DC  = 5;
   localparam int unsigned IC_BS  = 4;
   localparam int unsigned IC_FC  = 3;

   localparam logic [2:0] SEQ_DONE = 3'd4;

   localparam int unsigned CMD_DMA_BIT   = 7;
   localparam int unsigned CFG_QUIET_BIT = 6;
   localparam logic [7:0]  CFG_RESET     = 8'h07;

   typedef enum logic [6:0] {
      OP_NOP     = 7'h00,
      OP_FLUSH   = 7'h01,
      OP_SOFTRST = 7'h02,
      OP_BUSRST  = 7'h03
   } sis_op_e;
endpackage

// File: rtl/sis_xfer_count.sv
module sis_xfer_count #(
   parameter int unsigned NBYTES = 3
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclr,
   input  logic [NBYTES-1:0]   wr_sel,
   input  logic [7:0]          wdata,
   input  logic                reload,
   input  logic                zero,
   output logic [NBYTES*8-1:0] live,
   output logic                hi_written
);
   localparam int unsigned HI = NBYTES - 1;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic [7:0] shadow_q;
      logic [7:0] live_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
         end else if (sclr) begin
            shadow_q <= '0;
            live_q   <= '0;
         end else begin
            if (wr_sel[b]) shadow_q <= wdata;
            if (zero)        live_q <= '0;
            else if (reload) live_q <= shadow_q;
         end
      end
      assign live[b*8 +: 8] = live_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_written <= 1'b0;
      else if (sclr)      hi_written <= 1'b0;
      else if (wr_sel[HI]) hi_written <= 1'b1;
   end
endmodule

// File: rtl/sis_irq_core.sv
module sis_irq_core
   import scsi_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclr,
   input  logic       rd_intr,
   input  logic       cnt_wr,
   input  logic       flush,
   input  logic       busrst,
   input  logic       quiet,
   input  logic       ev_fc,
   input  logic       ev_bs,
   input  logic       ev_dc,
   input  logic       done,
   input  logic [7:0] done_st,
   output logic [7:0] stat_q,
   output logic [7:0] intr_q,
   output logic [2:0] seq_q,
   output logic [7:0] cst_q,
   output logic       def_q,
   output logic       report,
   output logic       irq
);
   logic [7:0] stat_d, intr_d, cst_d, defst_q, defst_d, rpt_st;
   logic [2:0] seq_d;
   logic       def_d;
   logic       int_busy;

   // pending interrupt that survives this cycle's cause read
   assign int_busy = stat_q[ST_INT] && !(rd_intr && !def_q);

   always_comb begin
      stat_d  = stat_q;
      intr_d  = intr_q;
      seq_d   = seq_q;
      cst_d   = cst_q;
      def_d   = def_q;
      defst_d = defst_q;
      report  = 1'b0;
      rpt_st  = defst_q;
      if (rd_intr) begin
         intr_d         = '0;
         stat_d[ST_INT] = 1'b0;
         stat_d[ST_TC]  = 1'b0;
         seq_d          = SEQ_DONE;
         if (def_q) begin
            report = 1'b1;
            rpt_st = defst_q;
            def_d  = 1'b0;
         end
      end
      if (cnt_wr) stat_d[ST_TC] = 1'b0;
      if (flush) begin
         intr_d         = '0;
         intr_d[IC_FC]  = 1'b1;
         seq_d          = '0;
      end
      if (busrst) begin
         intr_d         = '0;
         intr_d[IC_RST] = 1'b1;
         if (!quiet) stat_d[ST_INT] = 1'b1;
      end
      if (done) begin
         if (int_busy) begin
            def_d   = 1'b1;
            defst_d = done_st;
         end else begin
            report = 1'b1;
            rpt_st = done_st;
         end
      end
      if (report) begin
         stat_d         = '0;
         stat_d[ST_INT] = 1'b1;
         stat_d[ST_TC]  = 1'b1;
         stat_d[2:0]    = PH_STATUS;
         intr_d         = '0;
         intr_d[IC_BS]  = 1'b1;
         seq_d          = '0;
         cst_d          = rpt_st;
      end
      if (ev_fc || ev_bs || ev_dc) begin
         intr_d[IC_FC]  = intr_d[IC_FC] | ev_fc;
         intr_d[IC_BS]  = intr_d[IC_BS] | ev_bs;
         intr_d[IC_DC]  = intr_d[IC_DC] | ev_dc;
         stat_d[ST_INT] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0; intr_q <= '0; seq_q <= '0; cst_q <= '0;
         def_q  <= 1'b0; defst_q <= '0;
      end else if (sclr) begin
         stat_q <= '0; intr_q <= '0; seq_q <= '0; cst_q <= '0;
         def_q  <= 1'b0; defst_q <= '0;
      end else begin
         stat_q <= stat_d; intr_q <= intr_d; seq_q <= seq_d; cst_q <= cst_d;
         def_q  <= def_d;  defst_q <= defst_d;
      end
   end

   assign irq = stat_q[ST_INT];
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
   import scsi_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_BYTES = 3,
   parameter logic [7:0]  CHIP_ID   = 8'hA2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              ev_func_done,
   input  logic              ev_bus_service,
   input  logic              ev_disconnect,
   input  logic              ev_cmd_done,
   input  logic [7:0]        cmd_done_status,
   output logic              irq
);
   localparam int unsigned HI_IDX = CNT_BYTES - 1;

   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("scsi_irq_status: ADDR_W must be at least 4");
   end
   if (CNT_BYTES < 1 || CNT_BYTES > 3) begin : g_bad_cnt
      $error("scsi_irq_status: CNT_BYTES must be 1 to 3");
   end

   logic [CNT_BYTES-1:0]   cnt_sel;
   logic [CNT_BYTES*8-1:0] live_cnt;
   logic                   cnt_wr, wr_cmd, wr_cfg, rd_intr;
   logic                   soft_clr, do_reload, do_flush, do_busrst, report;
   sis_op_e                op;
   logic [7:0]             cfg_q, cmd_q, rdata_q, rd_mux;
   logic [7:0]             stat_q, intr_q, cst_q;
   logic [2:0]             seq_q;
   logic                   def_pend, hi_written;

   for (genvar b = 0; b < CNT_BYTES; b++) begin : g_sel
      assign cnt_sel[b] = reg_wr && (reg_addr == ADDR_W'(b));
   end

   assign cnt_wr    = |cnt_sel;
   assign wr_cmd    = reg_wr && (reg_addr == ADDR_W'(ADR_CMD));
   assign wr_cfg    = reg_wr && (reg_addr == ADDR_W'(ADR_CFG));
   assign rd_intr   = reg_rd && (reg_addr == ADDR_W'(ADR_INTR));
   assign op        = sis_op_e'(reg_wdata[6:0]);
   assign soft_clr  = wr_cmd && (op == OP_SOFTRST);
   assign do_reload = wr_cmd && reg_wdata[CMD_DMA_BIT];
   assign do_flush  = wr_cmd && (op == OP_FLUSH);
   assign do_busrst = wr_cmd && (op == OP_BUSRST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
         cmd_q <= '0;
      end else if (soft_clr) begin
         cfg_q <= CFG_RESET;
         cmd_q <= '0;
      end else begin
         if (wr_cfg) cfg_q <= reg_wdata;
         if (wr_cmd) cmd_q <= reg_wdata;
      end
   end

   sis_xfer_count #(.NBYTES(CNT_BYTES)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclr       (soft_clr),
      .wr_sel     (cnt_sel),
      .wdata      (reg_wdata),
      .reload     (do_reload),
      .zero       (report),
      .live       (live_cnt),
      .hi_written (hi_written)
   );

   sis_irq_core u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclr    (soft_clr),
      .rd_intr (rd_intr),
      .cnt_wr  (cnt_wr),
      .flush   (do_flush),
      .busrst  (do_busrst),
      .quiet   (cfg_q[CFG_QUIET_BIT]),
      .ev_fc   (ev_func_done),
      .ev_bs   (ev_bus_service),
      .ev_dc   (ev_disconnect),
      .done    (ev_cmd_done),
      .done_st (cmd_done_status),
      .stat_q  (stat_q),
      .intr_q  (intr_q),
      .seq_q   (seq_q),
      .cst_q   (cst_q),
      .def_q   (def_pend),
      .report  (report),
      .irq     (irq)
   );

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < CNT_BYTES; b++) begin
         if (reg_addr == ADDR_W'(b)) rd_mux = live_cnt[b*8 +: 8];
      end
      if (reg_addr == ADDR_W'(HI_IDX) && !hi_written) rd_mux = CHIP_ID;
      if (reg_addr == ADDR_W'(ADR_CMD))  rd_mux = cmd_q;
      if (reg_addr == ADDR_W'(ADR_STAT)) rd_mux = stat_q;
      if (reg_addr == ADDR_W'(ADR_INTR)) rd_mux = intr_q;
      if (reg_addr == ADDR_W'(ADR_SEQ))  rd_mux = {5'b0, seq_q};
      if (reg_addr == ADDR_W'(ADR_CFG))  rd_mux = cfg_q;
      if (reg_addr == ADDR_W'(ADR_CST))  rd_mux = cst_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux;
   end

   assign reg_rdata = rdata_q;
endmodule

// File: rtl/sis_checker.sv
module sis_checker
   import scsi_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_BYTES = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              ev_func_done,
   input logic              ev_bus_service,
   input logic              ev_disconnect,
   input logic              ev_cmd_done,
   input logic              irq,
   input logic [7:0]        stat_q,
   input logic              def_pend
);
   logic ev_any, rd_cause;
   assign ev_any   = ev_func_done || ev_bus_service || ev_disconnect;
   assign rd_cause = reg_rd && (reg_addr == ADDR_W'(ADR_INTR));

   p_event_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_any && !reg_wr) |=> irq);

   p_irq_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_rd && !reg_wr) |=> irq);

   p_read_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cause && !def_pend && !ev_any && !ev_cmd_done && !reg_wr) |=> !irq);

   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cause && def_pend && !ev_cmd_done && !reg_wr) |=> (irq && !def_pend));

   p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_cmd_done && irq && !reg_rd && !reg_wr) |=> def_pend);

   p_held_needs_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
      def_pend |-> irq);

   p_count_write_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr < ADDR_W'(CNT_BYTES)) && !reg_rd && !ev_cmd_done)
      |=> !stat_q[ST_TC]);
endmodule

bind scsi_irq_status sis_checker #(.ADDR_W(ADDR_W), .CNT_BYTES(CNT_BYTES)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .reg_wr         (reg_wr),
   .reg_rd         (reg_rd),
   .reg_addr       (reg_addr),
   .ev_func_done   (ev_func_done),
   .ev_bus_service (ev_bus_service),
   .ev_disconnect  (ev_disconnect),
   .ev_cmd_done    (ev_cmd_done),
   .irq            (irq),
   .stat_q         (stat_q),
   .def_pend       (def_pend)
);

// File: tb/tb_scsi_irq_status.sv
`timescale 1ns/1ps
module tb_scsi_irq_status;
   localparam logic [7:0] ID = 8'hA2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       ev_fc = 1'b0, ev_bs = 1'b0, ev_dc = 1'b0, ev_done = 1'b0;
   logic [7:0] done_st = '0;
   logic       irq;

   always #2.5 clk = ~clk;

   scsi_irq_status dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_func_done(ev_fc), .ev_bus_service(ev_bs), .ev_disconnect(ev_dc),
      .ev_cmd_done(ev_done), .cmd_done_status(done_st), .irq(irq)
   );

   int checks = 0, errors = 0;

   // reference model
   logic [7:0] m_stat, m_intr, m_cfg, m_cmd, m_cst, m_defst;
   logic [2:0] m_seq;
   logic       m_def, m_hiw;
   logic [7:0] m_sh [3];
   logic [7:0] m_live [3];

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic m_reset();
      m_stat = 0; m_intr = 0; m_seq = 0; m_cst = 0; m_def = 0; m_defst = 0;
      m_cfg = 8'h07; m_cmd = 0; m_hiw = 0;
      for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_live[i] = 0; end
   endtask

   task automatic m_report(input logic [7:0] st);
      m_stat = 8'h93; m_intr = 8'h10; m_seq = 0; m_cst = st;
      for (int i = 0; i < 3; i++) m_live[i] = 0;
   endtask

   function automatic logic [7:0] exp_read(input logic [3:0] a);
      case (a)
         4'd0: return m_live[0];
         4'd1: return m_live[1];
         4'd2: return m_hiw ? m_live[2] : ID;
         4'd3: return m_cmd;
         4'd4: return m_stat;
         4'd5: return m_intr;
         4'd6: return {5'b0, m_seq};
         4'd8: return m_cfg;
         4'd9: return m_cst;
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'd0, 4'd1: return "R8";
         4'd2: return "R7";
         4'd3: return "R8";
         4'd4, 4'd9: return "R5";
         4'd5, 4'd6: return "R3";
         4'd8: return "R1";
         default: return "R12";
      endcase
   endfunction

   task automatic m_write(input logic [3:0] a, input logic [7:0] d);
      if (a <= 4'd2) begin
         m_sh[a] = d; m_stat[4] = 1'b0;
         if (a == 4'd2) m_hiw = 1'b1;
      end else if (a == 4'd3) begin
         m_cmd = d;
         if (d[7]) for (int i = 0; i < 3; i++) m_live[i] = m_sh[i];
         case (d[6:0])
            7'h01: begin m_intr = 8'h08; m_seq = 0; end
            7'h02: m_reset();
            7'h03: begin m_intr = 8'h80; if (!m_cfg[6]) m_stat[7] = 1'b1; end
            default: ;
         endcase
      end else if (a == 4'd8) m_cfg = d;
   endtask

   task automatic op_write(input logic [3:0] a, input logic [7:0] d, input string req);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
      m_write(a, d);
      chk(irq == m_stat[7], req, {7'b0, irq}, {7'b0, m_stat[7]});
   endtask

   task automatic op_read(input logic [3:0] a, input string req, input bit lit, input logic [7:0] lv);
      logic [7:0] e;
      e = exp_read(a);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); reg_rd = 1'b0;
      chk(reg_rdata == e, req, reg_rdata, e);
      if (lit) chk(reg_rdata == lv, req, reg_rdata, lv);
      if (a == 4'd5) begin
         m_intr = 0; m_stat[4] = 0; m_stat[7] = 0; m_seq = 3'd4;
         if (m_def) begin m_def = 0; m_report(m_defst); end
      end
      chk(irq == m_stat[7], req, {7'b0, irq}, {7'b0, m_stat[7]});
   endtask

   // kind: 0 fc, 1 bs, 2 dc, 3 completion
   task automatic op_event(input int kind, input logic [7:0] st, input string req);
      @(negedge clk);
      case (kind)
         0: ev_fc = 1'b1;
         1: ev_bs = 1'b1;
         2: ev_dc = 1'b1;
         default: begin ev_done = 1'b1; done_st = st; end
      endcase
      @(negedge clk); ev_fc = 0; ev_bs = 0; ev_dc = 0; ev_done = 0;
      case (kind)
         0: begin m_intr[3] = 1'b1; m_stat[7] = 1'b1; end
         1: begin m_intr[4] = 1'b1; m_stat[7] = 1'b1; end
         2: begin m_intr[5] = 1'b1; m_stat[7] = 1'b1; end
         default: if (m_stat[7]) begin m_def = 1'b1; m_defst = st; end
                  else m_report(st);
      endcase
      chk(irq == m_stat[7], req, {7'b0, irq}, {7'b0, m_stat[7]});
   endtask

   initial begin
      #500us;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(irq == 1'b0, "R1", {7'b0, irq}, 8'h00);
      op_read(4'd2, "R1", 1, ID);
      op_read(4'd8, "R1", 1, 8'h07);
      op_read(4'd4, "R1", 1, 8'h00);
      op_read(4'd5, "R1", 1, 8'h00);
      op_read(4'd0, "R1", 1, 8'h00);
      // R2 events and R3 destructive read
      op_event(0, 0, "R2");
      op_read(4'd4, "R2", 1, 8'h80);
      op_event(2, 0, "R2");
      op_read(4'd5, "R3", 1, 8'h28);
      op_read(4'd5, "R3", 1, 8'h00);
      op_read(4'd6, "R3", 1, 8'h04);
      // R6 / R7 / R8 counts
      op_write(4'd0, 8'h11, "R6");
      op_write(4'd1, 8'h22, "R6");
      op_read(4'd0, "R6", 1, 8'h00);
      op_read(4'd2, "R7", 1, ID);
      op_write(4'd2, 8'h33, "R7");
      op_read(4'd2, "R7", 1, 8'h00);
      op_write(4'd3, 8'h80, "R8");
      op_read(4'd0, "R8", 1, 8'h11);
      op_read(4'd2, "R8", 1, 8'h33);
      op_read(4'd3, "R8", 1, 8'h80);
      // R5 immediate completion
      op_event(3, 8'h02, "R5");
      op_read(4'd4, "R5", 1, 8'h93);
      op_read(4'd9, "R5", 1, 8'h02);
      op_read(4'd1, "R5", 1, 8'h00);
      op_read(4'd6, "R5", 1, 8'h00);
      op_write(4'd1, 8'h05, "R6");
      op_read(4'd4, "R6", 1, 8'h83);
      // R4 deferred completion
      op_event(1, 0, "R4");
      op_event(3, 8'h55, "R4");
      op_read(4'd9, "R4", 1, 8'h02);
      op_read(4'd5, "R4", 1, 8'h10);
      chk(irq == 1'b1, "R4", {7'b0, irq}, 8'h01);
      op_read(4'd9, "R4", 1, 8'h55);
      op_read(4'd5, "R4", 1, 8'h10);
      // R9 bus reset command with and without suppress
      op_write(4'd8, 8'h47, "R9");
      op_write(4'd3, 8'h03, "R9");
      chk(irq == 1'b0, "R9", {7'b0, irq}, 8'h00);
      op_read(4'd5, "R9", 1, 8'h80);
      op_write(4'd8, 8'h07, "R9");
      op_write(4'd3, 8'h03, "R9");
      chk(irq == 1'b1, "R9", {7'b0, irq}, 8'h01);
      op_read(4'd5, "R9", 1, 8'h80);
      // R10 flush
      op_write(4'd3, 8'h01, "R10");
      op_read(4'd5, "R10", 1, 8'h08);
      op_read(4'd6, "R10", 1, 8'h04);
      op_write(4'd3, 8'h01, "R10");
      op_read(4'd6, "R10", 1, 8'h00);
      // R12 ignored writes
      op_write(4'd4, 8'hFF, "R12");
      op_write(4'd9, 8'hFF, "R12");
      op_write(4'd12, 8'hFF, "R12");
      op_read(4'd4, "R12", 0, 8'h00);
      op_read(4'd9, "R12", 0, 8'h00);
      op_read(4'd12, "R12", 1, 8'h00);
      // R11 soft reset
      op_event(0, 0, "R11");
      op_write(4'd8, 8'h3C, "R11");
      op_write(4'd3, 8'h02, "R11");
      chk(irq == 1'b0, "R11", {7'b0, irq}, 8'h00);
      op_read(4'd2, "R11", 1, ID);
      op_read(4'd8, "R11", 1, 8'h07);
      op_read(4'd3, "R11", 1, 8'h00);
      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         int sel;
         sel = $urandom_range(0, 9);
         if (sel <= 1) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 15));
            op_read(a, tag_of(a), 0, 8'h00);
         end else if (sel == 2) begin
            op_read(4'd5, "R3", 0, 8'h00);
         end else if (sel <= 4) begin
            int w;
            logic [3:0] a;
            logic [7:0] d;
            w = $urandom_range(0, 5);
            d = 8'($urandom_range(0, 255));
            case (w)
               0, 1, 2: a = 4'(w);
               3: begin
                  a = 4'd3;
                  d[6:0] = ($urandom_range(0, 4) == 4) ? d[6:0] : 7'($urandom_range(0, 3));
               end
               4: a = 4'd8;
               default: a = 4'($urandom_range(0, 15));
            endcase
            op_write(a, d, (a == 4'd3) ? "R8" : "R12");
         end else if (sel <= 7) begin
            op_event($urandom_range(0, 2), 0, "R2");
         end else begin
            op_event(3, 8'($urandom_range(0, 255)), "R4");
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule